// File: doc/BRIEF.md
# Execute Stage with Branch Resolution

This block is the execute stage of a small load/store processor. On every cycle that carries a valid instruction it takes a 4-bit opcode, two source operands `opB` and `opC`, and a branch target `tgtAddr`. One clock edge later it presents one of two results. A data operation gives a write-back value with its enable. A branch gives a taken flag with the target the program counter should load.

The data operations are add, subtract, multiply, signed divide, bitwise AND, OR and complement, and right shifts in arithmetic and logical forms. The branch side has one unconditional jump and six conditional branches. All six conditions come from a single signed comparison of `opB` against `opC`. Operand fetch, memory traffic and hazard detection happen in other stages. A cycle without a valid instruction leaves every output quiet on the next cycle.

Top module: `exec_branch_unit`

## Requirements
- R1: The 4-bit opcode selects the operation: 0 add, 1 subtract, 2 multiply, 3 divide, 4 AND, 5 OR, 6 complement, 7 arithmetic right shift, 8 logical right shift, 9 unconditional branch, 10 branch if equal, 11 branch if not equal, 12 branch if less, 13 branch if greater, 14 branch if less-or-equal, 15 branch if greater-or-equal. Outputs reflect the inputs sampled at the previous rising clock edge.
- R2: While the active-low reset is low, and on the first cycle after it rises, `wbEn`, `wbData`, `branchTaken`, `branchTarget` and `divZero` are all zero.
- R3: Add, subtract and multiply return `opB+opC`, `opB-opC` and the low 32 bits of `opB*opC`, wrapping in two's complement.
- R4: AND and OR return `opB&opC` and `opB|opC`. Complement returns `~opB`, and `opC` has no effect on it.
- R5: Arithmetic right shift moves `opB` right by `opC[4:0]` places and copies the sign bit into the vacated bits. Logical right shift does the same but fills with zeros. Bits 31:5 of `opC` are ignored.
- R6: Divide treats both operands as signed and truncates toward zero. The most negative value divided by -1 returns the most negative value, and `divZero` stays low in that case.
- R7: Divide with `opC` equal to zero returns all ones on `wbData` and raises `divZero` for that single result cycle.
- R8: The unconditional branch sets `branchTaken` and puts `tgtAddr` on `branchTarget` for exactly one cycle.
- R9: The conditional branches compare `opB` with `opC` as signed values. When the condition holds, the branch behaves like R8. When it fails, `branchTaken` is low and `branchTarget` is zero.
- R10: Data opcodes raise `wbEn` and never `branchTaken`. Branch opcodes never raise `wbEn`. Whenever `wbEn` is low, `wbData` is zero.
- R11: When `inValid` is low, the next cycle shows all outputs low or zero, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks the opcode and operands as a real instruction |
| opcode | input | 4 | Operation select, encoded as in R1 |
| opB | input | 32 | First source operand |
| opC | input | 32 | Second source operand or shift amount |
| tgtAddr | input | 32 | Branch destination |
| wbEn | output | 1 | Write-back enable for `wbData` |
| wbData | output | 32 | Result of a data operation |
| branchTaken | output | 1 | Branch resolved as taken |
| branchTarget | output | 32 | Destination of a taken branch, zero otherwise |
| divZero | output | 1 | The divide result came from a zero divisor |

## Verification
The assertions check the rules that hold on every cycle. Write-back and branch-taken are never high together. Data is zero whenever the enable is low. A zero-divisor flag always comes with an all-ones result. An idle cycle always leads to quiet outputs. The unconditional branch always lands on its target one cycle later. The arithmetic values themselves can only be shown by the bench's directed scenarios. These include wraparound sums, truncating division with mixed signs, shift amounts above 31, and signed compares where unsigned order would give the opposite answer.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_MUL = 4'd2,  OP_DIV = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_NOT = 4'd6,  OP_ASR = 4'd7,
    OP_LSR = 4'd8,  OP_JMP = 4'd9,  OP_JEQ = 4'd10, OP_JNE = 4'd11,
    OP_JLT = 4'd12, OP_JGT = 4'd13, OP_JLE = 4'd14, OP_JGE = 4'd15
  } opcode_e;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_MUL, FN_DIV, FN_AND, FN_OR, FN_NOT, FN_ASR, FN_LSR
  } aluFn_e;

  typedef enum logic [2:0] {
    BC_ALWAYS, BC_EQ, BC_NE, BC_LT, BC_GT, BC_LE, BC_GE
  } brCond_e;

  typedef struct packed {
    logic    wbEn;
    logic    isBranch;
    logic    isDiv;
    aluFn_e  aluFn;
    brCond_e brCond;
  } exuCtrl_t;

endpackage

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
(
  input  logic       inValid,
  input  logic [3:0] opcode,
  output exuCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{wbEn: 1'b0, isBranch: 1'b0, isDiv: 1'b0,
             aluFn: FN_ADD, brCond: BC_ALWAYS};
    if (inValid) begin
      unique case (opcode_e'(opcode))
        OP_ADD: begin ctrl.wbEn = 1'b1; ctrl.aluFn = FN_ADD; end
        OP_SUB: begin ctrl.wbEn = 1'b1; ctrl.aluFn = FN_SUB; end
        OP_MUL: begin ctrl.wbEn = 1'b1; ctrl.aluFn = FN_MUL; end
        OP_DIV: begin ctrl.wbEn = 1'b1; ctrl.aluFn = FN_DIV; ctrl.isDiv = 1'b1; end
        OP_AND: begin ctrl.wbEn = 1'b1; ctrl.aluFn = FN_AND; end
        OP_OR:  begin ctrl.wbEn = 1'b1; ctrl.aluFn = FN_OR;  end
        OP_NOT: begin ctrl.wbEn = 1'b1; ctrl.aluFn = FN_NOT; end
        OP_ASR: begin ctrl.wbEn = 1'b1; ctrl.aluFn = FN_ASR; end
        OP_LSR: begin ctrl.wbEn = 1'b1; ctrl.aluFn = FN_LSR; end
        OP_JMP: begin ctrl.isBranch = 1'b1; ctrl.brCond = BC_ALWAYS; end
        OP_JEQ: begin ctrl.isBranch = 1'b1; ctrl.brCond = BC_EQ; end
        OP_JNE: begin ctrl.isBranch = 1'b1; ctrl.brCond = BC_NE; end
        OP_JLT: begin ctrl.isBranch = 1'b1; ctrl.brCond = BC_LT; end
        OP_JGT: begin ctrl.isBranch = 1'b1; ctrl.brCond = BC_GT; end
        OP_JLE: begin ctrl.isBranch = 1'b1; ctrl.brCond = BC_LE; end
        OP_JGE: begin ctrl.isBranch = 1'b1; ctrl.brCond = BC_GE; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  exuCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [ADDR_W-1:0] tgtAddr,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbData,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              divZero
);

  localparam int SHAMT_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [SHAMT_W-1:0] shAmt;
  logic [DATA_W-1:0]  aluRes;
  logic               cZero, divWrap, isEq, isLt, condMet;

  assign shAmt   = opC[SHAMT_W-1:0];
  assign cZero   = (opC == '0);
  assign divWrap = (opB == MOST_NEG) && (opC == '1);
  assign isEq    = (opB == opC);
  assign isLt    = ($signed(opB) < $signed(opC));

  always_comb begin
    unique case (ctrl.aluFn)
      FN_ADD:  aluRes = opB + opC;
      FN_SUB:  aluRes = opB - opC;
      FN_MUL:  aluRes = opB * opC;
      FN_DIV: begin
        if (cZero)        aluRes = '1;
        else if (divWrap) aluRes = MOST_NEG;
        else              aluRes = $unsigned($signed(opB) / $signed(opC));
      end
      FN_AND:  aluRes = opB & opC;
      FN_OR:   aluRes = opB | opC;
      FN_NOT:  aluRes = ~opB;
      FN_ASR:  aluRes = $unsigned($signed(opB) >>> shAmt);
      FN_LSR:  aluRes = opB >> shAmt;
      default: aluRes = '0;
    endcase
  end

  always_comb begin
    unique case (ctrl.brCond)
      BC_ALWAYS: condMet = 1'b1;
      BC_EQ:     condMet = isEq;
      BC_NE:     condMet = !isEq;
      BC_LT:     condMet = isLt;
      BC_GT:     condMet = !isLt && !isEq;
      BC_LE:     condMet = isLt || isEq;
      BC_GE:     condMet = !isLt;
      default:   condMet = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbEn         <= 1'b0;
      wbData       <= '0;
      branchTaken  <= 1'b0;
      branchTarget <= '0;
      divZero      <= 1'b0;
    end else begin
      wbEn         <= ctrl.wbEn;
      wbData       <= ctrl.wbEn ? aluRes : '0;
      branchTaken  <= ctrl.isBranch && condMet;
      branchTarget <= (ctrl.isBranch && condMet) ? tgtAddr : '0;
      divZero      <= ctrl.isDiv && cZero;
    end
  end

  // R10: write-back and branch are mutually exclusive
  p_wb_or_branch_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(wbEn && branchTaken));

  // R10: idle write-back carries no data
  p_quiet_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wbEn |-> (wbData == '0));

  // R9: a not-taken branch leaves the target at zero
  p_quiet_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    !branchTaken |-> (branchTarget == '0));

  // R7: zero-divisor flag always comes with an all-ones result
  p_divzero_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> (wbEn && wbData == '1));

  // R7: a divide by zero raises the flag on the next cycle
  p_divzero_raise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.isDiv && opC == '0) |=> divZero);

  // R8: unconditional branch lands on its target one cycle later
  p_jump_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.isBranch && ctrl.brCond == BC_ALWAYS) |=>
      (branchTaken && branchTarget == $past(tgtAddr)));

  // R11: an idle control word leads to quiet outputs
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.wbEn && !ctrl.isBranch) |=> (!wbEn && !branchTaken && !divZero));

endmodule

// File: rtl/exec_branch_unit.sv
module exec_branch_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [ADDR_W-1:0] tgtAddr,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbData,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              divZero
);

  exuCtrl_t ctrl;

  exu_ctrl u_ctrl (
    .inValid (inValid),
    .opcode  (opcode),
    .ctrl    (ctrl)
  );

  exu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .opB          (opB),
    .opC          (opC),
    .tgtAddr      (tgtAddr),
    .wbEn         (wbEn),
    .wbData       (wbData),
    .branchTaken  (branchTaken),
    .branchTarget (branchTarget),
    .divZero      (divZero)
  );

endmodule

// File: tb/exec_branch_unit_tb.sv
module exec_branch_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] opB = '0, opC = '0, tgtAddr = '0;
  logic        wbEn, branchTaken, divZero;
  logic [31:0] wbData, branchTarget;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exec_branch_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opB(opB), .opC(opC), .tgtAddr(tgtAddr),
    .wbEn(wbEn), .wbData(wbData), .branchTaken(branchTaken),
    .branchTarget(branchTarget), .divZero(divZero)
  );

  task automatic chk(string tag, logic eWb, logic [31:0] eData,
                     logic eTk, logic [31:0] eTgt, logic eDz);
    checks++;
    if (wbEn !== eWb || wbData !== eData || branchTaken !== eTk ||
        branchTarget !== eTgt || divZero !== eDz) begin
      fails++;
      $display("FAIL %s: got wb=%0b data=%h tk=%0b tgt=%h dz=%0b, exp wb=%0b data=%h tk=%0b tgt=%h dz=%0b",
               tag, wbEn, wbData, branchTaken, branchTarget, divZero,
               eWb, eData, eTk, eTgt, eDz);
    end
  endtask

  // apply one instruction, wait one edge, sample away from the edge
  task automatic issue(logic v, logic [3:0] op, logic [31:0] b,
                       logic [31:0] c, logic [31:0] a);
    @(negedge clk);
    inValid = v; opcode = op; opB = b; opC = c; tgtAddr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic dataOp(string tag, logic [3:0] op, logic [31:0] b,
                        logic [31:0] c, logic [31:0] exp);
    issue(1'b1, op, b, c, 32'hDEAD_BEEF);
    chk(tag, 1'b1, exp, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic brOp(string tag, logic [3:0] op, logic [31:0] b,
                      logic [31:0] c, logic taken);
    issue(1'b1, op, b, c, 32'h0000_4A20);
    chk(tag, 1'b0, 32'h0, taken, taken ? 32'h0000_4A20 : 32'h0, 1'b0);
  endtask

  task automatic testReset();
    #1 chk("R2 during reset", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R2 first cycle after reset", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic testArith();
    dataOp("R3 R1 add", 4'd0, 32'd5, 32'd7, 32'd12);
    dataOp("R3 add wrap", 4'd0, 32'hFFFF_FFFF, 32'd1, 32'h0);
    dataOp("R3 sub negative", 4'd1, 32'd3, 32'd5, 32'hFFFF_FFFE);
    dataOp("R3 mul low bits", 4'd2, 32'h0001_0000, 32'h0001_0000, 32'h0);
    dataOp("R3 mul signed", 4'd2, 32'hFFFF_FFFD, 32'd7, 32'hFFFF_FFEB);
  endtask

  task automatic testLogic();
    dataOp("R4 and", 4'd4, 32'h0000_F0F0, 32'h0000_FF00, 32'h0000_F000);
    dataOp("R4 or", 4'd5, 32'h0000_F0F0, 32'h0000_FF00, 32'h0000_FFF0);
    dataOp("R4 not ignores c", 4'd6, 32'h0000_FFFF, 32'h0000_007B, 32'hFFFF_0000);
    dataOp("R4 not c ones", 4'd6, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000);
  endtask

  task automatic testShift();
    dataOp("R5 asr sign fill", 4'd7, 32'h8000_0000, 32'd4, 32'hF800_0000);
    dataOp("R5 asr upper c ignored", 4'd7, 32'h8000_0000, 32'd36, 32'hF800_0000);
    dataOp("R5 asr positive", 4'd7, 32'h4000_0000, 32'd30, 32'h0000_0001);
    dataOp("R5 lsr zero fill", 4'd8, 32'h8000_0000, 32'd4, 32'h0800_0000);
    dataOp("R5 lsr amount 32 is 0", 4'd8, 32'h8000_0000, 32'd32, 32'h8000_0000);
    dataOp("R5 lsr by 31", 4'd8, 32'hFFFF_FFFF, 32'd31, 32'h0000_0001);
  endtask

  task automatic testDivide();
    dataOp("R6 div plain", 4'd3, 32'd7, 32'd2, 32'd3);
    dataOp("R6 div neg dividend", 4'd3, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFD);
    dataOp("R6 div neg divisor", 4'd3, 32'd7, 32'hFFFF_FFFE, 32'hFFFF_FFFD);
    dataOp("R6 div most neg by -1", 4'd3, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000);
  endtask

  task automatic testDivZero();
    issue(1'b1, 4'd3, 32'd5, 32'd0, 32'h0);
    chk("R7 div by zero", 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b1);
    dataOp("R7 flag drops next op", 4'd0, 32'd1, 32'd0, 32'd1);
    issue(1'b1, 4'd0, 32'd9, 32'd0, 32'h0);
    chk("R7 add with zero c no flag", 1'b1, 32'd9, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic testJump();
    brOp("R8 jump taken", 4'd9, 32'd1, 32'd2, 1'b1);
    issue(1'b0, 4'd9, 32'd1, 32'd2, 32'h0000_4A20);
    chk("R8 R11 jump lasts one cycle", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic testCond();
    // b=-1, c=1: signed order is b<c
    brOp("R9 eq false", 4'd10, 32'hFFFF_FFFF, 32'd1, 1'b0);
    brOp("R9 ne true", 4'd11, 32'hFFFF_FFFF, 32'd1, 1'b1);
    brOp("R9 lt signed", 4'd12, 32'hFFFF_FFFF, 32'd1, 1'b1);
    brOp("R9 gt signed", 4'd13, 32'hFFFF_FFFF, 32'd1, 1'b0);
    brOp("R9 le signed", 4'd14, 32'hFFFF_FFFF, 32'd1, 1'b1);
    brOp("R9 ge signed", 4'd15, 32'hFFFF_FFFF, 32'd1, 1'b0);
    // equal operands
    brOp("R9 eq true", 4'd10, 32'd9, 32'd9, 1'b1);
    brOp("R9 ne false", 4'd11, 32'd9, 32'd9, 1'b0);
    brOp("R9 lt equal", 4'd12, 32'd9, 32'd9, 1'b0);
    brOp("R9 gt equal", 4'd13, 32'd9, 32'd9, 1'b0);
    brOp("R9 le equal", 4'd14, 32'd9, 32'd9, 1'b1);
    brOp("R9 ge equal", 4'd15, 32'd9, 32'd9, 1'b1);
    // b=5, c=-2
    brOp("R9 gt true", 4'd13, 32'd5, 32'hFFFF_FFFE, 1'b1);
    brOp("R9 lt false", 4'd12, 32'd5, 32'hFFFF_FFFE, 1'b0);
  endtask

  task automatic testIdle();
    issue(1'b1, 4'd0, 32'd2, 32'd2, 32'h0);
    issue(1'b0, 4'd3, 32'd5, 32'd0, 32'h0000_0100);
    chk("R11 R10 idle divide quiet", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
    issue(1'b0, 4'd9, 32'd0, 32'd0, 32'h0000_0100);
    chk("R11 idle jump quiet", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
    issue(1'b1, 4'd5, 32'h1, 32'h2, 32'h0);
    @(negedge clk);
    rstN = 1'b0;
    #1 chk("R2 reset mid-run", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    testReset();
    testArith();
    testLogic();
    testShift();
    testDivide();
    testDivZero();
    testJump();
    testCond();
    testIdle();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule